// File: doc/BRIEF.md
# Configuration Register Bank with Sticky Bits

A bank of 32-bit configuration registers behind a simple memory-mapped bus. The bus has a select strobe, a write enable, a byte address, write data and registered read data. A write takes effect at the clock edge where select and write enable are both high. A read strobe (select high, write enable low) loads the read data register at that edge.

Each register applies its own per-bit write discipline:
- plain masked read/write bits;
- a bit that software may clear but never set;
- lock bits that software may set but never clear;
- accumulate-only protect words;
- a flag that is cleared by writing one to it and set by a hardware parity-error pulse.

Every stored value is also driven out on a dedicated port for neighbouring logic. Offsets that are unmapped or misaligned inside the 1 KiB window read as zero and ignore writes.

Top module: `cfg_regbank`

## Requirements
- R1: After reset, the control word (offset 0x04) reads 0x7C000001, and every other register reads 0.
- R2: The remap word (offset 0x00) stores only the written bits under mask 0x00000107. All other bits read 0.
- R3: Control word bits under mask 0xFCFF0100 are plain read/write. Bits outside that mask and outside bit 0 read 0.
- R4: Control word bit 0 is cleared by writing 0 to it. Writing 1 never sets it. Only reset restores it.
- R5: The four line-select words sit at offsets 0x08, 0x0C, 0x10 and 0x14. Each keeps the low 16 bits of a write. Word k drives line_sel_q[16k+15:16k].
- R6: Config word 2 (offset 0x1C) bits 3:0 are locks. Writing 1 sets a lock bit. Writing 0 leaves it unchanged. Only reset clears it.
- R7: Config word 2 bit 8 is set by a parity_err pulse and cleared by writing 1 to it. When a pulse and a clearing write occur in the same cycle, the bit ends up set. All other bits of this word read 0.
- R8: The two protect words (offsets 0x20 and 0x28) OR each written value into their contents. Their bits clear only on reset.
- R9: The key word (offset 0x24) keeps the low 8 bits of a write. The erase word (offset 0x18) ignores writes and reads 0.
- R10: Any of the following reads 0 and changes no register when written: an offset above 0x28 in the window, or an address with bits 1:0 not both 0.
- R11: rdata changes only at the edge of a read strobe. It holds the value addressed at that edge until the next read strobe.

Each register also drives a dedicated output port: remap_q, cfg1_q, line_sel_q, cfg2_q, wp1_q, key_q and wp2_q.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel | input | 1 | Access strobe |
| wr | input | 1 | 1 = write, 0 = read |
| addr | input | 10 | Byte address within the window |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| parity_err | input | 1 | Hardware parity-error event pulse |
| remap_q | output | 32 | Remap word contents |
| cfg1_q | output | 32 | Control word contents |
| line_sel_q | output | 64 | Four line-select words, word 0 in the low 16 bits |
| cfg2_q | output | 32 | Config word 2 contents |
| wp1_q | output | 32 | Protect word 1 contents |
| key_q | output | 8 | Key byte |
| wp2_q | output | 32 | Protect word 2 contents |

## Verification
A write updates the register outputs at the same edge that samples it. The bench drives each access on a falling edge and checks the output ports on the next falling edge, one cycle later. A read strobe loads rdata at its rising edge, so each read is checked on the falling edge that follows, and a write immediately before the read is already visible. A parity pulse shows up in cfg2_q one edge after it is driven. Hold checks leave sel low for several cycles, and change the register underneath, before sampling rdata again.

// File: rtl/cfg_regbank.sv
module cfg_regbank #(
  parameter int ADDR_W = 10,
  parameter int LINES  = 4,
  parameter int LINE_W = 16,
  parameter int KEY_W  = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      sel,
  input  logic                      wr,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [31:0]               wdata,
  output logic [31:0]               rdata,
  input  logic                      parity_err,
  output logic [31:0]               remap_q,
  output logic [31:0]               cfg1_q,
  output logic [LINES*LINE_W-1:0]   line_sel_q,
  output logic [31:0]               cfg2_q,
  output logic [31:0]               wp1_q,
  output logic [KEY_W-1:0]          key_q,
  output logic [31:0]               wp2_q
);
  localparam int IW = ADDR_W - 2;
  localparam logic [IW-1:0] IX_REMAP = IW'(0);
  localparam logic [IW-1:0] IX_CFG1  = IW'(1);
  localparam logic [IW-1:0] IX_LINE0 = IW'(2);
  localparam logic [IW-1:0] IX_ERASE = IW'(2 + LINES);
  localparam logic [IW-1:0] IX_CFG2  = IW'(3 + LINES);
  localparam logic [IW-1:0] IX_WP1   = IW'(4 + LINES);
  localparam logic [IW-1:0] IX_KEY   = IW'(5 + LINES);
  localparam logic [IW-1:0] IX_WP2   = IW'(6 + LINES);
  localparam logic [31:0] REMAP_MSK = 32'h0000_0107;
  localparam logic [31:0] CFG1_MSK  = 32'hFCFF_0100;
  localparam logic [31:0] CFG1_RST  = 32'h7C00_0001;
  localparam int LOCK_W = 4;
  localparam int PEF_BIT = 8;

  logic [IW-1:0] idx;
  logic          aligned, wen, ren;

  assign idx     = addr[ADDR_W-1:2];
  assign aligned = (addr[1:0] == 2'b00);
  assign wen     = sel & wr & aligned;
  assign ren     = sel & ~wr;

  logic [31:0]       remap_r, cfg1_r, wp1_r, wp2_r;
  logic [LOCK_W-1:0] lock_r;
  logic              pef_r;
  logic [KEY_W-1:0]  key_r;
  logic [LINE_W-1:0] line_r [LINES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remap_r <= '0;
      cfg1_r  <= CFG1_RST;
      wp1_r   <= '0;
      wp2_r   <= '0;
      key_r   <= '0;
    end else if (wen) begin
      case (idx)
        IX_REMAP: remap_r <= wdata & REMAP_MSK;
        IX_CFG1:  cfg1_r  <= (cfg1_r & wdata & 32'h1) | (wdata & CFG1_MSK);
        IX_WP1:   wp1_r   <= wp1_r | wdata;
        IX_WP2:   wp2_r   <= wp2_r | wdata;
        IX_KEY:   key_r   <= wdata[KEY_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_r <= '0;
      pef_r  <= 1'b0;
    end else begin
      if (wen && idx == IX_CFG2)
        lock_r <= lock_r | wdata[LOCK_W-1:0];
      if (parity_err)
        pef_r <= 1'b1;
      else if (wen && idx == IX_CFG2 && wdata[PEF_BIT])
        pef_r <= 1'b0;
    end
  end

  for (genvar i = 0; i < LINES; i++) begin : g_line
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        line_r[i] <= '0;
      else if (wen && idx == IX_LINE0 + IW'(i))
        line_r[i] <= wdata[LINE_W-1:0];
    end
    assign line_sel_q[i*LINE_W +: LINE_W] = line_r[i];
  end

  logic [31:0] cfg2_w, rd_mux;
  assign cfg2_w = {{(31-PEF_BIT){1'b0}}, pef_r, {(PEF_BIT-LOCK_W){1'b0}}, lock_r};

  always_comb begin
    rd_mux = '0;
    case (idx)
      IX_REMAP: rd_mux = remap_r;
      IX_CFG1:  rd_mux = cfg1_r;
      IX_ERASE: rd_mux = '0;
      IX_CFG2:  rd_mux = cfg2_w;
      IX_WP1:   rd_mux = wp1_r;
      IX_KEY:   rd_mux = {{(32-KEY_W){1'b0}}, key_r};
      IX_WP2:   rd_mux = wp2_r;
      default: ;
    endcase
    for (int i = 0; i < LINES; i++)
      if (idx == IX_LINE0 + IW'(i))
        rd_mux = {{(32-LINE_W){1'b0}}, line_r[i]};
    if (!aligned)
      rd_mux = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rdata <= '0;
    else if (ren)
      rdata <= rd_mux;
  end

  assign remap_q = remap_r;
  assign cfg1_q  = cfg1_r;
  assign cfg2_q  = cfg2_w;
  assign wp1_q   = wp1_r;
  assign wp2_q   = wp2_r;
  assign key_q   = key_r;
endmodule

// File: rtl/cfg_regbank_chk.sv
module cfg_regbank_chk #(
  parameter int ADDR_W = 10,
  parameter int LINES  = 4,
  parameter int LINE_W = 16,
  parameter int KEY_W  = 8
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    sel,
  input logic                    wr,
  input logic [ADDR_W-1:0]       addr,
  input logic [31:0]             rdata,
  input logic                    parity_err,
  input logic [31:0]             remap_q,
  input logic [31:0]             cfg1_q,
  input logic [LINES*LINE_W-1:0] line_sel_q,
  input logic [31:0]             cfg2_q,
  input logic [31:0]             wp1_q,
  input logic [KEY_W-1:0]        key_q,
  input logic [31:0]             wp2_q
);
  logic unmapped;
  assign unmapped = (addr[1:0] != 2'b00) || (int'(addr[ADDR_W-1:2]) > 6 + LINES);

  // R1
  reset_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (cfg1_q == 32'h7C00_0001 && wp1_q == 32'h0 && cfg2_q == 32'h0));

  // R4
  fw_bit_no_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(cfg1_q[0]));

  // R6
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ((cfg2_q[3:0] & $past(cfg2_q[3:0])) == $past(cfg2_q[3:0])));

  // R7
  parity_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    parity_err |=> cfg2_q[8]);

  // R8
  protect_accum_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ((wp1_q & $past(wp1_q)) == $past(wp1_q) &&
                      (wp2_q & $past(wp2_q)) == $past(wp2_q)));

  // R10
  unmapped_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && !wr && unmapped) |=> (rdata == 32'h0));

  // R10
  unmapped_write_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && wr && unmapped) |=> ($stable(remap_q) && $stable(cfg1_q) && $stable(wp1_q) &&
                                 $stable(wp2_q) && $stable(key_q) && $stable(line_sel_q)));

  // R11
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(sel && !wr) |=> $stable(rdata));
endmodule

bind cfg_regbank cfg_regbank_chk #(
  .ADDR_W(ADDR_W), .LINES(LINES), .LINE_W(LINE_W), .KEY_W(KEY_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .sel(sel), .wr(wr), .addr(addr), .rdata(rdata),
  .parity_err(parity_err), .remap_q(remap_q), .cfg1_q(cfg1_q),
  .line_sel_q(line_sel_q), .cfg2_q(cfg2_q), .wp1_q(wp1_q), .key_q(key_q),
  .wp2_q(wp2_q)
);

// File: tb/sim_cfg_regbank.sv
module sim_cfg_regbank;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, sel = 1'b0, wr = 1'b0, parity_err = 1'b0;
  logic [9:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata, remap_q, cfg1_q, cfg2_q, wp1_q, wp2_q;
  logic [63:0] line_sel_q;
  logic [7:0]  key_q;

  cfg_regbank u0 (
    .clk(clk), .rst_n(rst_n), .sel(sel), .wr(wr), .addr(addr), .wdata(wdata),
    .rdata(rdata), .parity_err(parity_err), .remap_q(remap_q), .cfg1_q(cfg1_q),
    .line_sel_q(line_sel_q), .cfg2_q(cfg2_q), .wp1_q(wp1_q), .key_q(key_q),
    .wp2_q(wp2_q)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 0;

  logic [31:0] m_remap, m_cfg1, m_wp1, m_wp2;
  logic [15:0] m_line [4];
  logic [3:0]  m_lock;
  logic        m_pef;
  logic [7:0]  m_key;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_remap = 0; m_cfg1 = 32'h7C00_0001; m_wp1 = 0; m_wp2 = 0;
    m_lock = 0; m_pef = 0; m_key = 0;
    for (int i = 0; i < 4; i++) m_line[i] = 0;
  endtask

  task automatic model_write(logic [9:0] a, logic [31:0] d, bit par);
    if (a[1:0] == 0) begin
      case (a)
        10'h00: m_remap = d & 32'h107;
        10'h04: m_cfg1 = {d[31:1] & 31'h7E7F_8080, m_cfg1[0] & d[0]};
        10'h08: m_line[0] = d[15:0];
        10'h0C: m_line[1] = d[15:0];
        10'h10: m_line[2] = d[15:0];
        10'h14: m_line[3] = d[15:0];
        10'h1C: begin m_lock = m_lock | d[3:0]; if (d[8]) m_pef = 0; end
        10'h20: m_wp1 = m_wp1 | d;
        10'h24: m_key = d[7:0];
        10'h28: m_wp2 = m_wp2 | d;
        default: ;
      endcase
    end
    if (par) m_pef = 1;
  endtask

  function automatic logic [31:0] model_read(logic [9:0] a);
    if (a[1:0] != 0) return 0;
    case (a)
      10'h00: return m_remap;
      10'h04: return m_cfg1;
      10'h08: return {16'h0, m_line[0]};
      10'h0C: return {16'h0, m_line[1]};
      10'h10: return {16'h0, m_line[2]};
      10'h14: return {16'h0, m_line[3]};
      10'h1C: return {23'h0, m_pef, 4'h0, m_lock};
      10'h20: return m_wp1;
      10'h24: return {24'h0, m_key};
      10'h28: return m_wp2;
      default: return 0;
    endcase
  endfunction

  task automatic bus_write(logic [9:0] a, logic [31:0] d, bit par = 0);
    @(negedge clk);
    sel = 1; wr = 1; addr = a; wdata = d; parity_err = par;
    @(negedge clk);
    sel = 0; wr = 0; parity_err = 0;
    model_write(a, d, par);
  endtask

  task automatic bus_read(logic [9:0] a, output logic [31:0] d);
    @(negedge clk);
    sel = 1; wr = 0; addr = a;
    @(negedge clk);
    sel = 0;
    d = rdata;
  endtask

  function automatic string tag_of(logic [9:0] a);
    case (a)
      10'h00: return "R2";
      10'h04: return "R3";
      10'h08, 10'h0C, 10'h10, 10'h14: return "R5";
      10'h1C: return "R6";
      10'h20, 10'h28: return "R8";
      10'h18, 10'h24: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic check_ports(string tag);
    chk({tag, " R2 remap_q"}, remap_q, m_remap);
    chk({tag, " R3 cfg1_q"}, cfg1_q, m_cfg1);
    chk({tag, " R5 line_sel_q"}, line_sel_q, {m_line[3], m_line[2], m_line[1], m_line[0]});
    chk({tag, " R6 cfg2_q"}, cfg2_q, {23'h0, m_pef, 4'h0, m_lock});
    chk({tag, " R8 wp1_q"}, wp1_q, m_wp1);
    chk({tag, " R8 wp2_q"}, wp2_q, m_wp2);
    chk({tag, " R9 key_q"}, key_q, m_key);
  endtask

  task automatic check_all_reads(string tag);
    logic [31:0] v;
    for (int w = 0; w < 11; w++) begin
      bus_read(10'(w * 4), v);
      chk({tag, " ", tag_of(10'(w * 4)), " read"}, v, model_read(10'(w * 4)));
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    model_reset();
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000 && !done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=%0d expected<150000", cyc);
      finish_run();
    end
  end

  initial begin
    logic [31:0] v, pat, held;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    check_ports("R1");
    check_all_reads("R1");
    chk("R11 rdata after reset", rdata, model_read(10'h28));

    // R2 R3 R4 R5 R6 R7 R8 R9 per-bit sweep over every mapped offset
    for (int w = 0; w < 11; w++) begin
      for (int p = 0; p < 35; p++) begin
        pat = (p < 32) ? (32'h1 << p) : (p == 32) ? 32'hFFFF_FFFF : (p == 33) ? 32'h0 : 32'hA5A5_A5A5;
        bus_write(10'(w * 4), pat);
        check_ports(tag_of(10'(w * 4)));
        bus_read(10'(w * 4), v);
        chk({tag_of(10'(w * 4)), " sweep read"}, v, model_read(10'(w * 4)));
      end
    end
    chk("R4 fw bit stays clear after writing 1", cfg1_q[0], 1'b0);

    // R1 R4 R6 R8 reset restores sticky bits
    do_reset();
    check_ports("R1 after mid reset");
    chk("R4 fw bit restored by reset", cfg1_q[0], 1'b1);
    bus_write(10'h04, 32'h0000_0001);
    chk("R4 writing 1 keeps bit 0", cfg1_q[0], 1'b1);
    bus_write(10'h04, 32'h0);
    chk("R4 writing 0 clears bit 0", cfg1_q[0], 1'b0);
    bus_write(10'h04, 32'hFFFF_FFFF);
    chk("R4 R3 ones after clear", cfg1_q, 32'hFCFF_0100);

    // R6 locks
    bus_write(10'h1C, 32'h5);
    bus_write(10'h1C, 32'h0);
    chk("R6 lock unchanged by 0", cfg2_q[3:0], 4'h5);
    bus_write(10'h1C, 32'hA);
    chk("R6 lock accumulates", cfg2_q[3:0], 4'hF);

    // R7 parity flag
    @(negedge clk); parity_err = 1;
    @(negedge clk); parity_err = 0; model_write(10'h3FC, 0, 1);
    chk("R7 parity pulse sets flag", cfg2_q[8], 1'b1);
    bus_write(10'h1C, 32'h0);
    chk("R7 write 0 keeps flag", cfg2_q[8], 1'b1);
    bus_write(10'h1C, 32'h100);
    chk("R7 write 1 clears flag", cfg2_q[8], 1'b0);
    bus_write(10'h1C, 32'h100, 1);
    chk("R7 set wins over clear", cfg2_q[8], 1'b1);
    bus_read(10'h1C, v);
    chk("R7 read cfg2", v, 32'h10F);

    // R8 accumulate
    bus_write(10'h20, 32'h0000_00F0);
    bus_write(10'h20, 32'h0F00_0000);
    bus_write(10'h20, 32'h0);
    chk("R8 wp1 OR", wp1_q, 32'h0F00_00F0);
    bus_write(10'h28, 32'h8000_0001);
    bus_write(10'h28, 32'h0000_0100);
    chk("R8 wp2 OR", wp2_q, 32'h8000_0101);

    // R9 erase word ignores writes
    bus_write(10'h18, 32'hFFFF_FFFF);
    bus_read(10'h18, v);
    chk("R9 erase word reads 0", v, 32'h0);
    check_ports("R9 after erase write");

    // R10 unmapped sweep
    for (int w = 11; w < 256; w++) begin
      bus_write(10'(w * 4), 32'hFFFF_FFFF);
      bus_read(10'(w * 4), v);
      chk("R10 unmapped read", v, 32'h0);
    end
    check_ports("R10 after unmapped writes");
    check_all_reads("R10 after unmapped writes");

    // R10 misaligned
    for (int w = 0; w < 11; w++) begin
      for (int b = 1; b < 4; b++) begin
        bus_write(10'(w * 4 + b), 32'h5A5A_5A5A);
        bus_read(10'(w * 4 + b), v);
        chk("R10 misaligned read", v, 32'h0);
      end
    end
    check_ports("R10 after misaligned writes");

    // R11 read data holds
    bus_write(10'h24, 32'h0000_003C);
    bus_read(10'h24, held);
    bus_write(10'h24, 32'h0000_00C3);
    repeat (4) @(negedge clk);
    chk("R11 rdata held", rdata, 32'h3C);
    bus_read(10'h24, v);
    chk("R11 new read", v, 32'hC3);
    bus_write(10'h08, 32'h1234_BEEF);
    bus_read(10'h08, v);
    chk("R11 R5 read after write", v, 32'hBEEF);

    done = 1;
    finish_run();
  end
endmodule